// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes one received Ethernet frame at a time from a byte stream and places it into a packet RAM that is organised as a circular ring of 256-byte pages. The ring spans the pages from a start page up to, but not including, a stop page. Two page pointers track the ring. The current page marks where the next frame will go and is owned by this block. The boundary page marks how far the host has read and is supplied from outside.

At the start of each frame the block decides whether to keep it. A frame is discarded when the controller is halted or when the free space in the ring cannot hold a frame of the largest size. A discarded frame is still consumed from the stream, but nothing is written to RAM. A kept frame is stored from offset 4 of the current page onward and may wrap from the top of the ring back to its bottom. Frames shorter than the minimum length are extended with zero bytes. Finally a 4-byte header is written at offset 0 of the page. The current page then moves to the page after the frame, and a one-cycle received pulse goes to the interrupt logic.

The host can load the current page while no frame is pending. The RAM itself and host reads of it lie outside this block, which drives only the RAM write port.

Top module: `rx_ring_writer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `cur_pg` equals the parameter RST_PG (default 0), and `in_ready`, `ram_we` and `pkt_rcvd` are all 0.
- R2: If `halt` is 1 when a frame's first byte is presented, the whole frame is consumed with `in_ready` high, `ram_we` stays 0, `cur_pg` keeps its value and `pkt_rcvd` does not pulse.
- R3: The free space is counted in bytes with c = current page and b = boundary. When c < b it is (b - c) × 256. Otherwise it is ((stop - start) - (c - b)) × 256. A frame whose free space is below MAX_FRAME + 4 (default 1518) is consumed with no RAM write, no pointer change and no pulse. A frame whose free space is at or above that value is stored.
- R4: A stored frame shorter than MIN_FRAME (default 60) bytes is followed by zero bytes up to MIN_FRAME. The stored length L equals the padded length + 4, and one frame causes exactly padded length + 4 RAM writes.
- R5: For base page p, the next page is n = p + floor((L + 4 + 255) / 256). When n is at or above the stop page, (stop - start) is subtracted from n once. In the cycle where `pkt_rcvd` is first high, `cur_pg` already equals n. `pkt_rcvd` is high for exactly one cycle per stored frame.
- R6: The header sits at byte addresses p×256 + 0..3, with these contents: offset 0 is the status byte 0x21 (bit 0 = received OK, bit 5 = group-address match), offset 1 is n, offset 2 is L[7:0] and offset 3 is L[15:8].
- R7: Payload byte i (padding included) goes to the address reached by stepping i times from p×256 + 4. One step adds 1, and an address that equals stop×256 is replaced by start×256. Every write lands in the ring.
- R8: `in_ready` is 0 in the cycle when a new frame's first byte is first presented. It is also 0 from the cycle after the last byte is accepted until the frame is committed.
- R9: With the block idle and `in_valid` low, `cur_ld` loads `cur_ld_pg` into `cur_pg` at the next edge. Otherwise `cur_pg` changes only on a frame commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_start_pg | input | PW | First page of the ring |
| ring_stop_pg | input | PW | Page just past the ring |
| bound_pg | input | PW | Host read boundary page |
| halt | input | 1 | Controller halted; drop incoming frames |
| cur_ld | input | 1 | Load the current page |
| cur_ld_pg | input | PW | Value for the current-page load |
| cur_pg | output | PW | Current page |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of the frame |
| in_ready | output | 1 | Byte accepted when valid and ready |
| ram_we | output | 1 | Packet RAM write enable |
| ram_addr | output | PW+8 | Packet RAM byte address |
| ram_wdata | output | 8 | Packet RAM write data |
| pkt_rcvd | output | 1 | One-cycle frame-stored pulse |

## Verification
The hardest cases to reach from the ports are a payload that crosses the stop page partway through a frame, and a next-page value that lands exactly on the stop page and must fold to the start. Random lengths alone reach these cases only by chance. The stimulus therefore loads the current page into the top one or two pages of the ring and sends lengths chosen so that the rounding reaches the stop page. The overflow threshold is approached the same way: the boundary is set one page either side of the exact limit, both below and above the current page, so both branches of the free-space rule are tested at their edge. Random frames with the boundary kept at the current page then cycle the ring many times.

// File: rtl/rxr_pkg.sv
// Shared definitions for the receive ring writer.
// Assumes: header layout and status bit positions are fixed by the
// host-side reader and are not parameters.
package rxr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,     // waiting for the first byte of a frame
        ST_PAYLOAD,  // storing stream bytes
        ST_DRAIN,    // consuming a rejected frame, no writes
        ST_PAD,      // extending a short frame with zeros
        ST_HDR       // writing the 4-byte page header
    } rxr_state_e;

    localparam int HDR_BYTES    = 4;
    localparam int STAT_OK_BIT  = 0;
    localparam int STAT_GRP_BIT = 5;
    localparam logic [7:0] RX_STATUS =
        (8'd1 << STAT_OK_BIT) | (8'd1 << STAT_GRP_BIT);

endpackage

// File: rtl/rxr_space_check.sv
// Decides whether the ring can take one more frame of maximum size.
// Assumes: start < stop and both pointers lie inside the ring, so the
// page difference never goes negative.
module rxr_space_check #(
    parameter int PW        = 8,
    parameter int MAX_FRAME = 1514
) (
    input  logic [PW-1:0] start_pg,
    input  logic [PW-1:0] stop_pg,
    input  logic [PW-1:0] cur_pg,
    input  logic [PW-1:0] bound_pg,
    output logic          room_ok
);
    localparam int FW = PW + 9;
    localparam logic [FW-1:0] NEED_BYTES = FW'(MAX_FRAME + 4);

    logic [PW:0]   free_pg;
    logic [FW-1:0] free_bytes;

    // free pages between the write pointer and the host boundary
    always_comb begin
        if (cur_pg < bound_pg) begin
            free_pg = {1'b0, bound_pg} - {1'b0, cur_pg};
        end else begin
            free_pg = ({1'b0, stop_pg} - {1'b0, start_pg})
                    - ({1'b0, cur_pg} - {1'b0, bound_pg});
        end
        free_bytes = {free_pg, 8'h00};
        room_ok    = (free_bytes >= NEED_BYTES);
    end
endmodule

// File: rtl/rxr_next_page.sv
// Computes the page that follows a stored frame, folded into the ring.
// Assumes: the rounded span is smaller than the ring, so a single
// subtraction of the ring size is enough.
module rxr_next_page #(
    parameter int PW = 8,
    parameter int LW = 16
) (
    input  logic [PW-1:0] base_pg,
    input  logic [PW-1:0] start_pg,
    input  logic [PW-1:0] stop_pg,
    input  logic [LW-1:0] stored_len,
    output logic [PW-1:0] next_pg
);
    localparam int SW = LW + 1;

    logic [SW-1:0] span_pg;
    logic [SW-1:0] sum_pg;

    // round the header-plus-frame span up to pages and wrap once
    always_comb begin
        span_pg = (SW'(stored_len) + SW'(4 + 255)) >> 8;
        sum_pg  = span_pg + SW'(base_pg);
        if (sum_pg >= SW'(stop_pg)) begin
            sum_pg = sum_pg - (SW'(stop_pg) - SW'(start_pg));
        end
        next_pg = sum_pg[PW-1:0];
    end
endmodule

// File: rtl/rxr_ptr_step.sv
// Advances a byte address by one, jumping from the stop address to
// the start address.
// Assumes: the pointer never starts above the stop address.
module rxr_ptr_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] stop_addr,
    output logic [AW-1:0] ptr_next
);
    logic [AW-1:0] ptr_inc;

    // increment with wrap at the top of the ring
    always_comb begin
        ptr_inc  = ptr + AW'(1);
        ptr_next = (ptr_inc == stop_addr) ? start_addr : ptr_inc;
    end
endmodule

// File: rtl/rx_ring_writer.sv
// Receive ring writer: stores stream frames into a paged packet RAM
// ring behind a 4-byte header and advances the current page.
// Assumes: ring limits and boundary are stable during a frame, the
// current page lies in the ring, and frames are at most MAX_FRAME long.
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int PW                 = 8,
    parameter int LW                 = 16,
    parameter int MAX_FRAME          = 1514,
    parameter int MIN_FRAME          = 60,
    parameter logic [PW-1:0] RST_PG  = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PW-1:0]   ring_start_pg,
    input  logic [PW-1:0]   ring_stop_pg,
    input  logic [PW-1:0]   bound_pg,
    input  logic            halt,
    input  logic            cur_ld,
    input  logic [PW-1:0]   cur_ld_pg,
    output logic [PW-1:0]   cur_pg,
    input  logic            in_valid,
    input  logic [7:0]      in_data,
    input  logic            in_last,
    output logic            in_ready,
    output logic            ram_we,
    output logic [PW+7:0]   ram_addr,
    output logic [7:0]      ram_wdata,
    output logic            pkt_rcvd
);
    localparam int AW = PW + 8;
    localparam int HW = $clog2(HDR_BYTES);

    rxr_state_e    state_q;
    logic [PW-1:0] base_q;
    logic [AW-1:0] ptr_q;
    logic [LW-1:0] cnt_q;
    logic [HW-1:0] hidx_q;
    logic [PW-1:0] cur_q;
    logic          rcvd_q;

    logic          room_ok;
    logic [PW-1:0] next_pg;
    logic [AW-1:0] ptr_nx;
    logic [LW-1:0] cnt_inc;
    logic [LW-1:0] stored_len;

    assign cnt_inc    = cnt_q + LW'(1);
    assign stored_len = cnt_q + LW'(HDR_BYTES);
    assign cur_pg     = cur_q;
    assign pkt_rcvd   = rcvd_q;

    rxr_space_check #(.PW(PW), .MAX_FRAME(MAX_FRAME)) u_space (
        .start_pg (ring_start_pg),
        .stop_pg  (ring_stop_pg),
        .cur_pg   (cur_q),
        .bound_pg (bound_pg),
        .room_ok  (room_ok)
    );

    rxr_next_page #(.PW(PW), .LW(LW)) u_next (
        .base_pg    (base_q),
        .start_pg   (ring_start_pg),
        .stop_pg    (ring_stop_pg),
        .stored_len (stored_len),
        .next_pg    (next_pg)
    );

    rxr_ptr_step #(.AW(AW)) u_step (
        .ptr        (ptr_q),
        .start_addr ({ring_start_pg, 8'h00}),
        .stop_addr  ({ring_stop_pg, 8'h00}),
        .ptr_next   (ptr_nx)
    );

    // stream handshake: bytes are taken only while storing or draining
    assign in_ready = (state_q == ST_PAYLOAD) || (state_q == ST_DRAIN);

    // RAM write port driven from the state and pointers
    always_comb begin
        ram_we    = 1'b0;
        ram_addr  = ptr_q;
        ram_wdata = in_data;
        unique case (state_q)
            ST_PAYLOAD: ram_we = in_valid;
            ST_PAD: begin
                ram_we    = 1'b1;
                ram_wdata = 8'h00;
            end
            ST_HDR: begin
                ram_we   = 1'b1;
                ram_addr = {base_q, 8'(hidx_q)};
                unique case (hidx_q)
                    2'd0:    ram_wdata = RX_STATUS;
                    2'd1:    ram_wdata = 8'(next_pg);
                    2'd2:    ram_wdata = stored_len[7:0];
                    default: ram_wdata = stored_len[15:8];
                endcase
            end
            default: ram_we = 1'b0;
        endcase
    end

    // frame sequencing, pointer updates and commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            ptr_q   <= '0;
            cnt_q   <= '0;
            hidx_q  <= '0;
            cur_q   <= RST_PG;
            rcvd_q  <= 1'b0;
        end else begin
            rcvd_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        base_q  <= cur_q;
                        ptr_q   <= {cur_q, 8'(HDR_BYTES)};
                        cnt_q   <= '0;
                        state_q <= (halt || !room_ok) ? ST_DRAIN : ST_PAYLOAD;
                    end else if (cur_ld) begin
                        cur_q <= cur_ld_pg;
                    end
                end
                ST_PAYLOAD: begin
                    if (in_valid) begin
                        ptr_q <= ptr_nx;
                        cnt_q <= cnt_inc;
                        if (in_last) begin
                            hidx_q  <= '0;
                            state_q <= (cnt_inc < LW'(MIN_FRAME)) ? ST_PAD : ST_HDR;
                        end
                    end
                end
                ST_PAD: begin
                    ptr_q <= ptr_nx;
                    cnt_q <= cnt_inc;
                    if (cnt_inc >= LW'(MIN_FRAME)) begin
                        hidx_q  <= '0;
                        state_q <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    hidx_q <= hidx_q + HW'(1);
                    if (hidx_q == HW'(HDR_BYTES - 1)) begin
                        cur_q   <= next_pg;
                        rcvd_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_DRAIN: begin
                    if (in_valid && in_last) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R7: every RAM write stays between the start and stop pages
    p_ring_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_addr[AW-1:8] >= ring_start_pg) && (ram_addr[AW-1:8] < ring_stop_pg));

    // R2/R3: a rejected frame never reaches the RAM
    p_drain_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> !ram_we);

    // R4: the header is only written once the frame is at least minimum length
    p_padded_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR) |-> (cnt_q >= LW'(MIN_FRAME)));

    // R5: the received pulse lasts one cycle
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_rcvd |=> !pkt_rcvd);

    // R9: the current page moves only on a load or a commit
    p_cur_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q) |-> (pkt_rcvd || $past(cur_ld)));

endmodule

// File: tb/rx_ring_writer_bench.sv
`timescale 1ns/1ps
module rx_ring_writer_bench;
    localparam int PW     = 8;
    localparam int MAXF   = 1514;
    localparam int MINF   = 60;
    localparam int RSTART = 'h40;
    localparam int RSTOP  = 'h60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ring_start_pg = 8'(RSTART);
    logic [7:0]  ring_stop_pg  = 8'(RSTOP);
    logic [7:0]  bound_pg = '0;
    logic        halt = 1'b0;
    logic        cur_ld = 1'b0;
    logic [7:0]  cur_ld_pg = '0;
    logic [7:0]  cur_pg;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        pkt_rcvd;

    int n_chk = 0;
    int n_fail = 0;
    int wcnt = 0;
    int rc_cnt = 0;
    logic [7:0] cur_at_rc = '0;
    logic [7:0] mem [int];
    logic [7:0] fb [MAXF];

    always #4 clk = ~clk;

    rx_ring_writer u_rx_ring_writer (
        .clk(clk), .rst_n(rst_n),
        .ring_start_pg(ring_start_pg), .ring_stop_pg(ring_stop_pg),
        .bound_pg(bound_pg), .halt(halt),
        .cur_ld(cur_ld), .cur_ld_pg(cur_ld_pg), .cur_pg(cur_pg),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .pkt_rcvd(pkt_rcvd)
    );

    // RAM model and pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (ram_we) begin
                mem[int'(ram_addr)] = ram_wdata;
                wcnt++;
            end
            if (pkt_rcvd) begin
                rc_cnt++;
                cur_at_rc = cur_pg;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_room(input int s, input int e, input int c, input int b);
        int fp;
        if (c < b) fp = b - c;
        else       fp = (e - s) - (c - b);
        return (fp * 256) >= (MAXF + 4);
    endfunction

    function automatic int exp_next(input int base, input int slen);
        int n = base + (slen + 4 + 255) / 256;
        if (n >= RSTOP) n -= (RSTOP - RSTART);
        return n;
    endfunction

    function automatic int step_addr(input int a);
        int b = a + 1;
        if (b == RSTOP * 256) b = RSTART * 256;
        return b;
    endfunction

    task automatic load_cur(input int pg);
        @(negedge clk);
        cur_ld = 1'b1;
        cur_ld_pg = 8'(pg);
        @(negedge clk);
        cur_ld = 1'b0;
        check(int'(cur_pg) == pg, "R9", "current page after load", int'(cur_pg), pg);
    endtask

    // send one frame and check either its storage or its rejection
    task automatic run_frame(input int len, input string drop_req);
        int w0 = wcnt;
        int r0 = rc_cnt;
        int base = int'(cur_pg);
        int plen = (len < MINF) ? MINF : len;
        int slen = plen + 4;
        bit accept = !halt && exp_room(RSTART, RSTOP, base, int'(bound_pg));
        int nxt = exp_next(base, slen);
        int a;
        int bad_i;
        bit pay_ok;
        bit pad_ok;
        for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_data  = fb[i];
            in_last  = (i == len - 1);
            if (i == 0) check(in_ready == 1'b0, "R8", "ready at frame start", int'(in_ready), 0);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (accept) begin
            check(in_ready == 1'b0, "R8", "ready after last byte", int'(in_ready), 0);
            for (int k = 0; k < 150 && rc_cnt == r0; k++) @(negedge clk);
            repeat (3) @(negedge clk);
            check(rc_cnt - r0 == 1, "R5", "received pulses", rc_cnt - r0, 1);
            check(int'(cur_at_rc) == nxt, "R5", "page at pulse", int'(cur_at_rc), nxt);
            check(int'(cur_pg) == nxt, "R5", "page after frame", int'(cur_pg), nxt);
            check(wcnt - w0 == slen, "R4", "write count", wcnt - w0, slen);
            check(int'(mem[base*256 + 0]) == 'h21, "R6", "status byte", int'(mem[base*256 + 0]), 'h21);
            check(int'(mem[base*256 + 1]) == nxt, "R6", "next page byte", int'(mem[base*256 + 1]), nxt);
            check(int'(mem[base*256 + 2]) == (slen & 255), "R6", "length low", int'(mem[base*256 + 2]), slen & 255);
            check(int'(mem[base*256 + 3]) == (slen >> 8), "R6", "length high", int'(mem[base*256 + 3]), slen >> 8);
            a = base * 256 + 4;
            pay_ok = 1'b1;
            pad_ok = 1'b1;
            bad_i = -1;
            for (int i = 0; i < plen; i++) begin
                if (i < len) begin
                    if (!mem.exists(a) || mem[a] != fb[i]) begin
                        if (pay_ok) bad_i = i;
                        pay_ok = 1'b0;
                    end
                end else begin
                    if (!mem.exists(a) || mem[a] != 8'h00) pad_ok = 1'b0;
                end
                a = step_addr(a);
            end
            check(pay_ok, "R7", "payload placement (first bad index)", bad_i, -1);
            if (len < MINF) check(pad_ok, "R4", "zero padding", int'(pad_ok), 1);
        end else begin
            repeat (80) @(negedge clk);
            check(wcnt == w0, drop_req, "writes on dropped frame", wcnt - w0, 0);
            check(rc_cnt == r0, drop_req, "pulses on dropped frame", rc_cnt - r0, 0);
            check(int'(cur_pg) == base, drop_req, "page on dropped frame", int'(cur_pg), base);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (5) @(negedge clk);
        check(cur_pg == 8'h00, "R1", "reset page", int'(cur_pg), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cur_pg == 8'h00, "R1", "page after reset", int'(cur_pg), 0);
        check(in_ready == 1'b0, "R1", "ready after reset", int'(in_ready), 0);
        check(ram_we == 1'b0, "R1", "write enable after reset", int'(ram_we), 0);
        check(pkt_rcvd == 1'b0, "R1", "pulse after reset", int'(pkt_rcvd), 0);

        // directed lengths around padding and page rounding (R4, R5, R6)
        load_cur(RSTART);
        foreach (fb[i]) fb[i] = 8'h00;
        bound_pg = cur_pg; run_frame(1, "R3");
        bound_pg = cur_pg; run_frame(59, "R3");
        bound_pg = cur_pg; run_frame(60, "R3");
        bound_pg = cur_pg; run_frame(248, "R3");
        bound_pg = cur_pg; run_frame(249, "R3");
        bound_pg = cur_pg; run_frame(MAXF, "R3");

        // payload crossing the stop page, R7
        load_cur(RSTOP - 1);
        bound_pg = cur_pg; run_frame(600, "R3");
        check(int'(cur_pg) == RSTART + 2, "R7", "page after wrapped frame", int'(cur_pg), RSTART + 2);
        // next page lands exactly on stop, R5
        load_cur(RSTOP - 2);
        bound_pg = cur_pg; run_frame(400, "R3");
        check(int'(cur_pg) == RSTART, "R5", "fold on stop page", int'(cur_pg), RSTART);

        // overflow threshold with boundary above the current page, R3
        load_cur(RSTART);
        bound_pg = 8'(RSTART + 5); run_frame(200, "R3");
        load_cur(RSTART);
        bound_pg = 8'(RSTART + 6); run_frame(200, "R3");
        // overflow threshold with boundary below the current page, R3
        load_cur(RSTART + 28);
        bound_pg = 8'(RSTART + 1); run_frame(300, "R3");
        load_cur(RSTART + 28);
        bound_pg = 8'(RSTART + 2); run_frame(300, "R3");

        // halted controller, R2
        bound_pg = cur_pg;
        halt = 1'b1;
        run_frame(120, "R2");
        run_frame(1, "R2");
        halt = 1'b0;

        // random frames cycling the ring
        for (int f = 0; f < 25; f++) begin
            int len;
            if ($urandom_range(1, 0) == 1) len = $urandom_range(80, 1);
            else                           len = $urandom_range(MAXF, 1);
            bound_pg = cur_pg;
            run_frame(len, "R3");
        end

        finish_run();
    end
endmodule